// File: doc/BRIEF.md
# Systolic Edit-Distance Array

This block computes the edit distance between a short DNA source string and a target string that arrives one symbol per clock. The array is a chain of identical cells. Each cell holds one source symbol and owns one row of the dynamic-programming matrix. A target symbol enters the first cell together with its column boundary value, D(0,j) = j. It then moves one cell to the right on each clock, so every cell on one antidiagonal of the matrix updates in the same cycle. Symbols are 2-bit codes. Inserting or deleting a symbol costs 1. Substituting one symbol for a different one costs 2. A matching pair costs 0.

To use the block, load the source symbols through the load port. Then pulse `start`, which puts every cell back to its row boundary D(i,0) = i. Then stream the target with `tgt_valid`, and flag the final symbol with `tgt_last`. After the flagged symbol reaches the far end of the chain, the block presents the distance D(N_CELLS, m) for one cycle. The distance width follows from the cell count and the longest allowed target, so no intermediate value can overflow.

Top module: `edit_dist_array`

## Requirements
- R1: While reset is high, and in the first cycle after it, `dist_valid` is 0 and `dist_out` is 0.
- R2: When `load_en` is high at a clock edge, `load_sym` is written as the source symbol of cell `load_idx`. Index 0 is the first source symbol and index N_CELLS-1 is the last. Later distances use the new symbol.
- R3: `start` returns every row to its boundary and clears all symbols in flight. A target symbol presented in the same cycle as `start` is dropped. `dist_valid` is 0 in the cycle after `start`.
- R4: The reported distance is the minimum edit cost between the source and the target, with insert and delete each costing 1, a substitution of unequal codes costing 2, and equal codes costing 0.
- R5: `dist_valid` is high for exactly one cycle. That cycle begins N_CELLS-1 rising edges after the edge that accepts the symbol flagged by `tgt_last`. `dist_valid` is low in the cycle before it and in the cycle after it.
- R6: Idle cycles (`tgt_valid` low) between target symbols do not change the result.
- R7: A reported distance has the parity of N_CELLS+m, where m is the target length. It lies between |N_CELLS-m| and N_CELLS+m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write one source symbol |
| load_idx | input | $clog2(N_CELLS) | Source position to write |
| load_sym | input | 2 | Source symbol code |
| start | input | 1 | Begin a new target stream |
| tgt_valid | input | 1 | Target symbol present |
| tgt_sym | input | 2 | Target symbol code |
| tgt_last | input | 1 | Marks the final target symbol |
| dist_valid | output | 1 | Distance result strobe |
| dist_out | output | $clog2(N_CELLS+MAX_TGT+1) | Edit distance |

## Verification
The result is due N_CELLS-1 rising edges after the edge that accepts the last target symbol, because each cell adds one register stage. The bench drives inputs on falling edges. It counts falling edges from the one that follows the accepting edge. It expects `dist_valid` to be low on the count just before the due cycle, high with the reference distance on the due count, and low again one cycle later. The reset state is read in the first falling edge after reset is released. The start-clears behaviour is seen in the result of a stream that is aborted, or that begins with a junk symbol, whose distance would be wrong if anything from before the start survived.

// File: rtl/edit_pkg.sv
package edit_pkg;
  localparam int SYM_W = 2;
  localparam int COST_GAP = 1;
  localparam int COST_SUB = 2;
  typedef logic [SYM_W-1:0] sym_t;
endpackage

// File: rtl/edit_feeder.sv
module edit_feeder
  import edit_pkg::*;
#(
  parameter int DIST_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              tgt_valid,
  input  sym_t              tgt_sym,
  input  logic              tgt_last,
  output logic              f_valid,
  output sym_t              f_sym,
  output logic              f_last,
  output logic [DIST_W-1:0] f_dist
);
  // column index of the next target symbol minus one
  logic [DIST_W-1:0] col_q;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      col_q <= '0;
    end else if (tgt_valid) begin
      col_q <= col_q + DIST_W'(COST_GAP);
    end
  end

  // a symbol arriving with start is discarded
  assign f_valid = tgt_valid && !start;
  assign f_sym   = tgt_sym;
  assign f_last  = tgt_last;
  assign f_dist  = col_q + DIST_W'(COST_GAP);
endmodule

// File: rtl/edit_cell.sv
module edit_cell
  import edit_pkg::*;
#(
  parameter int DIST_W = 5,
  parameter int ROW    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ld_we,
  input  sym_t              ld_sym,
  input  logic              in_valid,
  input  sym_t              in_sym,
  input  logic              in_last,
  input  logic [DIST_W-1:0] in_dist,
  output logic              out_valid,
  output sym_t              out_sym,
  output logic              out_last,
  output logic [DIST_W-1:0] out_dist
);
  localparam logic [DIST_W-1:0] ROW_INIT  = DIST_W'(ROW);
  localparam logic [DIST_W-1:0] DIAG_INIT = DIST_W'(ROW - 1);

  sym_t              src_q;
  logic [DIST_W-1:0] own_q;   // D(i, j-1)
  logic [DIST_W-1:0] diag_q;  // D(i-1, j-1)
  logic [DIST_W-1:0] cand_up, cand_left, cand_diag, best;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
    end else if (ld_we) begin
      src_q <= ld_sym;
    end
  end

  always_comb begin
    cand_up   = in_dist + DIST_W'(COST_GAP);
    cand_left = own_q + DIST_W'(COST_GAP);
    cand_diag = diag_q + ((in_sym == src_q) ? '0 : DIST_W'(COST_SUB));
    best      = (cand_up < cand_left) ? cand_up : cand_left;
    if (cand_diag < best) begin
      best = cand_diag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      own_q     <= ROW_INIT;
      diag_q    <= DIAG_INIT;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (rst) begin
        out_dist <= '0;
        out_sym  <= '0;
      end
    end else if (in_valid) begin
      own_q     <= best;
      diag_q    <= in_dist;
      out_valid <= 1'b1;
      out_last  <= in_last;
      out_sym   <= in_sym;
      out_dist  <= best;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end
endmodule

// File: rtl/edit_dist_array.sv
module edit_dist_array
  import edit_pkg::*;
#(
  parameter  int N_CELLS = 8,
  parameter  int MAX_TGT = 16,
  localparam int IDX_W   = $clog2(N_CELLS),
  localparam int DIST_W  = $clog2(N_CELLS + MAX_TGT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [IDX_W-1:0]  load_idx,
  input  logic [1:0]        load_sym,
  input  logic              start,
  input  logic              tgt_valid,
  input  logic [1:0]        tgt_sym,
  input  logic              tgt_last,
  output logic              dist_valid,
  output logic [DIST_W-1:0] dist_out
);
  logic              ch_valid [0:N_CELLS];
  sym_t              ch_sym   [0:N_CELLS];
  logic              ch_last  [0:N_CELLS];
  logic [DIST_W-1:0] ch_dist  [0:N_CELLS];
  logic              unused_tail;

  edit_feeder #(.DIST_W(DIST_W)) u_feed (
    .clk(clk), .rst(rst), .start(start),
    .tgt_valid(tgt_valid), .tgt_sym(tgt_sym), .tgt_last(tgt_last),
    .f_valid(ch_valid[0]), .f_sym(ch_sym[0]), .f_last(ch_last[0]),
    .f_dist(ch_dist[0])
  );

  for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
    edit_cell #(.DIST_W(DIST_W), .ROW(g + 1)) u_cell (
      .clk(clk), .rst(rst), .start(start),
      .ld_we(load_en && (load_idx == IDX_W'(g))), .ld_sym(load_sym),
      .in_valid(ch_valid[g]), .in_sym(ch_sym[g]), .in_last(ch_last[g]),
      .in_dist(ch_dist[g]),
      .out_valid(ch_valid[g+1]), .out_sym(ch_sym[g+1]),
      .out_last(ch_last[g+1]), .out_dist(ch_dist[g+1])
    );
  end

  assign unused_tail = ^ch_sym[N_CELLS];
  assign dist_valid  = ch_valid[N_CELLS] && ch_last[N_CELLS];
  assign dist_out    = ch_dist[N_CELLS];
endmodule

// File: rtl/edit_dist_chk.sv
module edit_dist_chk #(
  parameter int N_CELLS = 8,
  parameter int DIST_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              tgt_valid,
  input logic              tgt_last,
  input logic              dist_valid,
  input logic [DIST_W-1:0] dist_out
);
  int   tcnt;
  int   lat;
  logic done;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      tcnt <= 0;
      lat  <= 0;
      done <= 1'b0;
    end else begin
      if (tgt_valid && !done) begin
        tcnt <= tcnt + 1;
        if (tgt_last) begin
          done <= 1'b1;
          lat  <= 0;
        end
      end else if (done) begin
        lat <= lat + 1;
      end
    end
  end

  // R7
  parity_chk: assert property (@(posedge clk) disable iff (rst)
    dist_valid |-> (dist_out[0] == 1'((N_CELLS + tcnt) % 2)));
  // R7
  upper_bound_chk: assert property (@(posedge clk) disable iff (rst)
    dist_valid |-> (int'(dist_out) <= N_CELLS + tcnt));
  // R7
  lower_bound_chk: assert property (@(posedge clk) disable iff (rst)
    dist_valid |-> (int'(dist_out) >= ((N_CELLS > tcnt) ? N_CELLS - tcnt : tcnt - N_CELLS)));
  // R3
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !dist_valid);
  // R5
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    dist_valid |-> (done && lat == N_CELLS - 1));
  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dist_valid |=> !dist_valid);
endmodule

bind edit_dist_array edit_dist_chk #(.N_CELLS(N_CELLS), .DIST_W(DIST_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .tgt_valid(tgt_valid),
  .tgt_last(tgt_last), .dist_valid(dist_valid), .dist_out(dist_out)
);

// File: tb/sim_edit_dist_array.sv
module sim_edit_dist_array;
  localparam int N  = 8;
  localparam int MT = 16;
  localparam int IW = $clog2(N);
  localparam int DW = $clog2(N + MT + 1);

  // [52:48] length, [47:32] idle-after mask, [31:0] symbols (symbol j at bits 2j+1:2j)
  localparam logic [52:0] VEC [0:7] = '{
    {5'd8,  16'h0000, 32'h0000_E4E4},
    {5'd8,  16'h0000, 32'h0000_FFFF},
    {5'd1,  16'h0000, 32'h0000_0000},
    {5'd16, 16'hA5A5, 32'h1B39_C4E2},
    {5'd5,  16'h0003, 32'h0000_0321},
    {5'd12, 16'h0000, 32'h00FE_4D17},
    {5'd16, 16'hFFFF, 32'h0000_0000},
    {5'd3,  16'h0002, 32'h0000_0039}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_en = 1'b0;
  logic [IW-1:0] load_idx = '0;
  logic [1:0]    load_sym = '0;
  logic          start = 1'b0;
  logic          tgt_valid = 1'b0;
  logic [1:0]    tgt_sym = '0;
  logic          tgt_last = 1'b0;
  logic          dist_valid;
  logic [DW-1:0] dist_out;

  logic [1:0] src_m [0:N-1];
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  edit_dist_array #(.N_CELLS(N), .MAX_TGT(MT)) u0 (
    .clk(clk), .rst(rst), .load_en(load_en), .load_idx(load_idx),
    .load_sym(load_sym), .start(start), .tgt_valid(tgt_valid),
    .tgt_sym(tgt_sym), .tgt_last(tgt_last), .dist_valid(dist_valid),
    .dist_out(dist_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_dist(input int len, input logic [31:0] s);
    int d [0:N][0:MT];
    for (int i = 0; i <= N; i++) d[i][0] = i;
    for (int j = 0; j <= MT; j++) d[0][j] = j;
    for (int i = 1; i <= N; i++) begin
      for (int j = 1; j <= len; j++) begin
        int sub, best;
        sub  = (src_m[i-1] == s[2*(j-1) +: 2]) ? 0 : 2;
        best = d[i-1][j] + 1;
        if (d[i][j-1] + 1 < best) best = d[i][j-1] + 1;
        if (d[i-1][j-1] + sub < best) best = d[i-1][j-1] + sub;
        d[i][j] = best;
      end
    end
    return d[N][len];
  endfunction

  task automatic load_src(input int idx, input logic [1:0] s);
    load_en  = 1'b1;
    load_idx = IW'(idx);
    load_sym = s;
    @(negedge clk);
    load_en  = 1'b0;
    src_m[idx] = s;
  endtask

  task automatic run(input int len, input logic [31:0] syms, input logic [15:0] gaps,
                     input bit junk, input int hand_exp, input string req);
    int exp;
    exp = ref_dist(len, syms);
    start     = 1'b1;
    tgt_valid = junk;   // R3: dropped if junk
    tgt_sym   = 2'd3;
    tgt_last  = 1'b0;
    @(negedge clk);
    start     = 1'b0;
    tgt_valid = 1'b0;
    for (int j = 0; j < len; j++) begin
      tgt_valid = 1'b1;
      tgt_sym   = syms[2*j +: 2];
      tgt_last  = (j == len - 1);
      @(negedge clk);
      tgt_valid = 1'b0;
      tgt_last  = 1'b0;
      if (gaps[j] && j != len - 1) @(negedge clk);
    end
    repeat (N - 2) @(negedge clk);
    check(!dist_valid, "R5 early", int'(dist_valid), 0);
    @(negedge clk);
    check(dist_valid, "R5 due", int'(dist_valid), 1);
    check(int'(dist_out) == exp, req, int'(dist_out), exp);
    if (hand_exp >= 0) check(int'(dist_out) == hand_exp, "R4 hand", int'(dist_out), hand_exp);
    check(dist_out[0] == 1'((N + len) % 2), "R7 parity", int'(dist_out[0]), (N + len) % 2);
    @(negedge clk);
    check(!dist_valid, "R5 pulse", int'(dist_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!dist_valid, "R1 valid in reset", int'(dist_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!dist_valid, "R1 valid", int'(dist_valid), 0);
    check(dist_out == '0, "R1 dist", int'(dist_out), 0);

    // source ACGTACGT as codes 0,1,2,3,0,1,2,3
    for (int i = 0; i < N; i++) load_src(i, 2'(i % 4));

    for (int v = 0; v < 8; v++) begin
      run(int'(VEC[v][52:48]), VEC[v][31:0], VEC[v][47:32], 1'b0,
          (v == 0) ? 0 : ((v == 1) ? 12 : -1),
          (VEC[v][47:32] != 0) ? "R6 gapped stream" : "R4 table stream");
    end

    // R3: junk symbol with start, then an aborted partial stream
    run(8, 32'h0000_E4E4, 16'h0000, 1'b1, 0, "R3 start drops symbol");
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j < 3; j++) begin
      tgt_valid = 1'b1;
      tgt_sym   = 2'd2;
      @(negedge clk);
    end
    tgt_valid = 1'b0;
    run(4, 32'h0000_00E4, 16'h0000, 1'b0, 4, "R3 abort then restart");

    // R2: reload first and last source symbols
    load_src(0, 2'd3);
    load_src(N - 1, 2'd0);
    run(8, 32'h0000_24E7, 16'h0000, 1'b0, 0, "R2 reloaded source");
    run(8, 32'h0000_E4E4, 16'h0000, 1'b0, 4, "R2 old target now differs");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule